// File: doc/BRIEF.md
# Buffered PWM Frequency-Modulation Channel

This block is one timer channel. It drives a single output whose period and duty cycle both come from programmable compare values. The channel has its own up-counter, which advances only on prescaler ticks. Each time the counter matches the period value it restarts at 1, and that restart begins a new cycle. A match on the duty value moves the output to the configured polarity level. A match on the period value moves it to the opposite level.

Software writes both compare values into shadow registers. While the channel is running, the shadows are copied into the active compare registers only at a cycle restart, so duty and period can be changed on the fly without a corrupted cycle. While the channel is disabled, writes go straight to the active registers, so the channel can be set up before it is started.

Top module: `pwmfm_chan`

## Requirements
- R1: After reset the output is 0, the counter holds 1, the active and shadow duty values are 0, and the active and shadow period values are all-ones.
- R2: In the clock where the mode enable is first seen high, the output is loaded with the polarity bit.
- R3: While enabled, the counter advances by one on each tick. A tick with the counter equal to the period value reloads it with 1. With 1 ≤ duty < period, each cycle holds the output at the inverse of polarity for duty ticks and at polarity for (period − duty) ticks. Each output edge comes one clock after the tick on which the match ends.
- R4: With one tick every two clocks, both output phases last twice as many clocks as with one tick per clock.
- R5: While enabled, a duty or period write takes effect at the next counter reload. A write in the same clock as a reload waits for the reload after that, and the cycle in progress completes with the old values.
- R6: While the mode is disabled, duty and period writes go straight to the active compare registers.
- R7: A period write with a value of 0 or 1 is ignored, and the previous period value is kept.
- R8: With duty equal to period, the period action wins, and the output stays constantly at the inverse of polarity (0% duty).
- R9: With duty equal to 0, the period match drives the output to polarity, and the output stays constantly at polarity (100% duty).
- R10: With duty greater than period, no duty match occurs, and once the first period match has happened the output stays at the inverse of polarity.
- R11: If the counter is above the period value when the mode is entered, it counts on to all-ones, wraps to 1, and normal cycles follow.
- R12: While the mode is disabled, the counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler enable, one clock wide |
| mode_en | input | 1 | Channel mode enable |
| edge_pol | input | 1 | Polarity level applied on a duty match |
| duty_wr | input | 1 | Write strobe for the duty value |
| duty_val | input | CW | Duty compare value to write |
| per_wr | input | 1 | Write strobe for the period value |
| per_val | input | CW | Period compare value to write |
| pwm_out | output | 1 | Channel output |

## Verification
The bench builds the channel with an 8-bit counter (CW = 8). With that width, the out-of-range entry case is reachable in a few hundred clocks: the counter runs past the period value, wraps at 255 and returns to normal cycles. Every other scenario uses small duty and period values that fit the narrow counter. The bench generates the prescaler itself at ratios 1 and 2 and measures the output phase lengths in clocks. That makes the one-clock edge delay, the ratio scaling and the boundary-synchronous update visible as exact phase lengths.

// File: rtl/pwmfm_chan.sv
module pwmfm_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_en,
  input  logic          edge_pol,
  input  logic          duty_wr,
  input  logic [CW-1:0] duty_val,
  input  logic          per_wr,
  input  logic [CW-1:0] per_val,
  output logic          pwm_out
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt, a_sh, b_sh, a_act, b_act;
  logic mode_q, pend_a, pend_b, b_lvl;

  wire run    = mode_en & tick;
  wire hit_a  = run & (cnt == a_act);
  wire hit_b  = run & (cnt == b_act);
  wire per_ok = per_wr & (per_val > ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= ONE;
      a_sh    <= '0;
      a_act   <= '0;
      b_sh    <= TOP;
      b_act   <= TOP;
      mode_q  <= 1'b0;
      pend_a  <= 1'b0;
      pend_b  <= 1'b0;
      b_lvl   <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      mode_q <= mode_en;
      if (run) cnt <= (hit_b || cnt == TOP) ? ONE : cnt + ONE;
      if (duty_wr) a_sh <= duty_val;
      if (per_ok) b_sh <= per_val;
      if (!mode_en) begin
        a_act <= duty_wr ? duty_val : a_sh;
        b_act <= per_ok ? per_val : b_sh;
      end else if (hit_b) begin
        a_act <= a_sh;
        b_act <= b_sh;
      end
      pend_a <= hit_a;
      pend_b <= hit_b;
      b_lvl  <= (a_act == '0) ? edge_pol : ~edge_pol;
      if (mode_en) begin
        if (!mode_q)     pwm_out <= edge_pol;
        else if (pend_b) pwm_out <= b_lvl;
        else if (pend_a) pwm_out <= edge_pol;
      end
    end
  end
endmodule

// File: rtl/pwmfm_chan_chk.sv
module pwmfm_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          mode_en,
  input logic          edge_pol,
  input logic          per_wr,
  input logic [CW-1:0] per_val,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] b_act,
  input logic [CW-1:0] b_sh
);
  // R2
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_en) |=> (pwm_out == $past(edge_pol)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> ($stable(pwm_out) && $stable(cnt)));

  // R7
  bad_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && per_val <= CW'(1)) |=> $stable(b_sh));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && tick && cnt == b_act) |=> (cnt == CW'(1)));

  // R3
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R11
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
endmodule

bind pwmfm_chan pwmfm_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_en(mode_en), .edge_pol(edge_pol),
  .per_wr(per_wr), .per_val(per_val), .pwm_out(pwm_out),
  .cnt(cnt), .b_act(b_act), .b_sh(b_sh)
);

// File: tb/tb_pwmfm_chan.sv
module tb_pwmfm_chan;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, tick = 0, mode_en = 0, edge_pol = 1;
  logic duty_wr = 0, per_wr = 0;
  logic [CW-1:0] duty_val = '0, per_val = '0;
  logic pwm_out;
  int checks = 0, fails = 0, ratio = 1, div = 0;
  bit done = 0;

  pwmfm_chan #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_en(mode_en), .edge_pol(edge_pol),
    .duty_wr(duty_wr), .duty_val(duty_val), .per_wr(per_wr), .per_val(per_val),
    .pwm_out(pwm_out));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (div >= ratio - 1) begin tick = 1; div = 0; end
    else begin tick = 0; div = div + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit d, input int dv, input bit p, input int pv);
    duty_wr = d; duty_val = CW'(dv); per_wr = p; per_val = CW'(pv);
    fork begin @(negedge clk); duty_wr = 0; per_wr = 0; end join_none
  endtask

  task automatic run_len(input bit lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic sync_start();
    int n;
    run_len(~edge_pol, n);
    run_len(edge_pol, n);
  endtask

  task automatic measure(input int a, input int b, input string req);
    int lo, hi;
    sync_start();
    run_len(~edge_pol, lo);
    run_len(edge_pol, hi);
    check(lo == a * ratio, req, lo, a * ratio);
    check(hi == (b - a) * ratio, req, hi, (b - a) * ratio);
  endtask

  task automatic const_level(input bit lvl, input int len, input string req);
    int bad = 0;
    repeat (len) begin @(negedge clk); if (pwm_out != lvl) bad++; end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    check(pwm_out == 1'b0, "R1", pwm_out, 0);
  endtask

  task automatic t_entry();
    wr(1, 3, 1, 8);
    @(negedge clk);
    mode_en = 1;
    @(negedge clk);
    check(pwm_out == 1'b1, "R2", pwm_out, 1);
  endtask

  task automatic t_basic();
    measure(3, 8, "R3 R6");
    measure(3, 8, "R3");
  endtask

  task automatic t_ratio2();
    ratio = 2;
    repeat (40) @(negedge clk);
    measure(3, 8, "R4");
    ratio = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_pol0();
    edge_pol = 0;
    repeat (20) @(negedge clk);
    measure(3, 8, "R3 polarity 0");
    edge_pol = 1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_buffer();
    int lo, hi, lo2, hi2;
    sync_start();
    wr(1, 2, 1, 6);
    run_len(~edge_pol, lo);
    run_len(edge_pol, hi);
    run_len(~edge_pol, lo2);
    run_len(edge_pol, hi2);
    check(lo == 3 && hi == 5, "R5 old cycle", lo * 100 + hi, 305);
    check(lo2 == 2 && hi2 == 4, "R5 new cycle", lo2 * 100 + hi2, 204);
  endtask

  task automatic t_badper();
    wr(0, 0, 1, 1);
    repeat (30) @(negedge clk);
    measure(2, 6, "R7 value 1");
    wr(0, 0, 1, 0);
    repeat (30) @(negedge clk);
    measure(2, 6, "R7 value 0");
  endtask

  task automatic t_zero();
    wr(1, 6, 0, 0);
    repeat (30) @(negedge clk);
    const_level(~edge_pol, 40, "R8");
  endtask

  task automatic t_full();
    wr(1, 0, 0, 0);
    repeat (30) @(negedge clk);
    const_level(edge_pol, 40, "R9");
  endtask

  task automatic t_over();
    wr(1, 9, 0, 0);
    repeat (30) @(negedge clk);
    const_level(~edge_pol, 40, "R10");
  endtask

  task automatic t_hold();
    bit v;
    wr(1, 3, 1, 8);
    repeat (30) @(negedge clk);
    sync_start();
    mode_en = 0;
    @(negedge clk);
    v = pwm_out;
    const_level(v, 50, "R12");
    mode_en = 1;
    @(negedge clk);
    check(pwm_out == edge_pol, "R2 re-entry", pwm_out, edge_pol);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_wrap();
    int n, lo, hi;
    mode_en = 0;
    wr(1, 100, 1, 200);
    @(negedge clk);
    mode_en = 1;
    repeat (2) @(negedge clk);
    sync_start();
    repeat (150) @(negedge clk);
    mode_en = 0;
    wr(1, 5, 1, 10);
    repeat (2) @(negedge clk);
    mode_en = 1;
    @(negedge clk);
    run_len(edge_pol, n);
    check(n >= 100 && n <= 140, "R11 wrap", n, 117);
    run_len(~edge_pol, lo);
    run_len(edge_pol, hi);
    check(lo == 5 && hi == 5, "R11 resume", lo * 100 + hi, 505);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_basic();
    t_ratio2();
    t_pol0();
    t_buffer();
    t_badper();
    t_zero();
    t_full();
    t_over();
    t_hold();
    t_wrap();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end
endmodule